// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target side of a two-wire serial bus placed in front of an 8192-byte array that writes with no delay. It watches the clock and data lines with the system clock and spots START and STOP conditions. It compares the device-select byte with a fixed four-bit code and three strap inputs. When the select matches, it either takes a two-byte memory address and a stream of write bytes, or streams read bytes out of the array. It drives the data line open-drain, so a high on `sda_oe` pulls the shared wire low.

A current-address register sits between transactions. A write transaction loads it. Every data byte read or written advances it, and it wraps at the top of the array. A read with no address phase uses it directly. To read at a chosen address, the host starts a write, sends the two address bytes, and then issues a repeated START with a read select. A protect input blocks array writes. While it is set, the block refuses to acknowledge data bytes and the address does not advance. The array connects through a single-cycle synchronous port: the address and write data are valid with a one-cycle write strobe, and read data returns one clock after the read strobe.

Top module: `serial_mem_target`

## Requirements
- R1: The block acknowledges a select byte only when bits 7..1 equal binary 1010 followed by strap[2:0]. Bit 0 set to 0 selects a write and set to 1 selects a read. On a mismatch the block gives no acknowledge and ignores the bus until the next START.
- R2: After a write select, the first address byte sets address bits 12..8 from its bits 4..0, and its bits 7..5 are ignored. The second byte sets address bits 7..0. The block acknowledges each address byte.
- R3: Reset sets the current address to 0. The address keeps its value across STOP and across repeated START. A read always starts at the current address.
- R4: The current address advances by one after each data byte, either on the write strobe or on the read fetch. It wraps from 0x1FFF to 0x0000.
- R5: Each unprotected write data byte gives exactly one write strobe, on the clock where its 8th bit is sampled, at the current address. The block then acknowledges the byte. A burst may be of any length.
- R6: Read bytes go out MSB first. A host ACK (data low) fetches and sends the next byte. A host NACK ends the read and releases SDA. SDA is released whenever the block is idle.
- R7: While wp is 1, write data bytes get no acknowledge, give no write strobe and leave the current address unchanged.
- R8: A START or STOP that comes before the 8th bit of a write data byte drops that byte. There is no strobe, and the address does not change.
- R9: The block has no busy state. A select that comes right after a write transaction is acknowledged.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock, already synchronised |
| sda_in | input | 1 | Bus data as seen on the wire, already synchronised |
| wp | input | 1 | Write protect, active high |
| strap | input | 3 | Select strap bits compared with select bits 3..1 |
| sda_oe | output | 1 | Pull the data wire low when 1 |
| mem_addr | output | 13 | Array address (the current address) |
| mem_we | output | 1 | One-cycle array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_re | output | 1 | One-cycle array read strobe |
| mem_rdata | input | 8 | Array read data, valid one clock after mem_re |

## Verification
A wrong current address does not show up at once. It shows on the next write strobe as a wrong `mem_addr`, or in the first byte of the next read, which may come several transactions later. The bench therefore keeps its own address model and checks every strobe as it fires. A bad bit counter or a bad state shifts the acknowledge slot, and that shows within one byte time as a wrong ACK or a misaligned read byte. An `sda_oe` edge while SCL is high would look like a false START or STOP, so that property is checked on every clock.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int SMT_ADDR_W = 13;
  localparam int SMT_STRAP_W = 3;

  typedef logic [SMT_ADDR_W-1:0] smt_addr_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_SEL_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } smt_state_e;

  // next sequential address; wraps at the top of the array
  function automatic smt_addr_t smt_next_addr(input smt_addr_t a);
    return a + smt_addr_t'(1);
  endfunction

  // select byte bits 7..1 against {family code, straps}
  function automatic logic smt_select_hit(input logic [7:0] sel,
                                          input logic [3:0] code,
                                          input logic [SMT_STRAP_W-1:0] strap);
    return sel[7:1] == {code, strap};
  endfunction
endpackage

// File: rtl/smt_line_events.sv
module smt_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/smt_addr_latch.sv
module smt_addr_latch
  import smt_pkg::*;
#(
  parameter int ADDR_W = SMT_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_hi,
  input  logic              load_lo,
  input  logic              bump,
  input  logic [ADDR_W-9:0] hi_in,
  input  logic [7:0]        lo_in,
  output smt_addr_t         cur
);
  localparam int HI_W = ADDR_W - 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (load_hi) begin
      cur[ADDR_W-1:8] <= hi_in[HI_W-1:0];
    end else if (load_lo) begin
      cur[7:0] <= lo_in;
    end else if (bump) begin
      cur <= smt_next_addr(cur);
    end
  end
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
  import smt_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl,
  input  logic                  sda_in,
  input  logic                  wp,
  input  logic [SMT_STRAP_W-1:0] strap,
  output logic                  sda_oe,
  output logic [SMT_ADDR_W-1:0] mem_addr,
  output logic                  mem_we,
  output logic [7:0]            mem_wdata,
  output logic                  mem_re,
  input  logic [7:0]            mem_rdata
);
  localparam int HI_W = SMT_ADDR_W - 8;

  smt_state_e state;
  logic [2:0] cnt;
  logic [6:0] shreg;
  logic [7:0] tx_q;
  logic [7:0] rbuf;
  logic       ack_q;
  logic       slot_q;
  logic       drive_q;
  logic       dir_rd_q;
  logic       re_q;
  logic       mack_q;

  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic rx_state, byte_done, sel_hit;
  logic [7:0] byte_in;
  logic load_hi, load_lo, wr_commit, rd_fetch;
  smt_addr_t cur_addr;

  // events brought out for the checker
  logic data_byte_done;
  logic in_idle;

  smt_line_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl),
    .sda      (sda_in),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  assign rx_state  = (state == ST_SEL) || (state == ST_AHI) ||
                     (state == ST_ALO) || (state == ST_WR);
  assign byte_in   = {shreg, sda_in};
  assign byte_done = scl_rise && (cnt == 3'd7) && rx_state && !start_ev && !stop_ev;
  assign sel_hit   = smt_select_hit(byte_in, DEV_CODE, strap);

  assign load_hi        = byte_done && (state == ST_AHI);
  assign load_lo        = byte_done && (state == ST_ALO);
  assign data_byte_done = byte_done && (state == ST_WR);
  assign wr_commit      = data_byte_done && !wp;
  assign rd_fetch       = (byte_done && (state == ST_SEL) && sel_hit && byte_in[0]) ||
                          ((state == ST_RD_ACK) && scl_rise && !sda_in);
  assign in_idle        = (state == ST_IDLE);

  smt_addr_latch #(.ADDR_W(SMT_ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_hi (load_hi),
    .load_lo (load_lo),
    .bump    (wr_commit || rd_fetch),
    .hi_in   (byte_in[HI_W-1:0]),
    .lo_in   (byte_in),
    .cur     (cur_addr)
  );

  assign mem_addr  = cur_addr;
  assign mem_we    = wr_commit;
  assign mem_wdata = byte_in;
  assign mem_re    = rd_fetch;

  // pull low during an ACK slot, or for a zero read bit
  assign sda_oe = drive_q | ((state == ST_RD) & ~tx_q[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      tx_q     <= '0;
      rbuf     <= '0;
      ack_q    <= 1'b0;
      slot_q   <= 1'b0;
      drive_q  <= 1'b0;
      dir_rd_q <= 1'b0;
      re_q     <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      re_q <= rd_fetch;
      if (re_q) rbuf <= mem_rdata;

      if (stop_ev) begin
        state   <= ST_IDLE;
        drive_q <= 1'b0;
        slot_q  <= 1'b0;
      end else if (start_ev) begin
        state   <= ST_SEL;
        cnt     <= '0;
        drive_q <= 1'b0;
        slot_q  <= 1'b0;
      end else begin
        unique case (state)
          ST_SEL, ST_AHI, ST_ALO, ST_WR: begin
            if (scl_rise) begin
              shreg <= byte_in[6:0];
              cnt   <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                unique case (state)
                  ST_SEL: begin
                    if (sel_hit) begin
                      ack_q    <= 1'b1;
                      dir_rd_q <= byte_in[0];
                      state    <= ST_SEL_ACK;
                    end else begin
                      state <= ST_IDLE;
                    end
                  end
                  ST_AHI: begin
                    ack_q <= 1'b1;
                    state <= ST_AHI_ACK;
                  end
                  ST_ALO: begin
                    ack_q <= 1'b1;
                    state <= ST_ALO_ACK;
                  end
                  default: begin
                    ack_q <= !wp;
                    state <= ST_WR_ACK;
                  end
                endcase
              end
            end
          end

          ST_SEL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              if (!slot_q) begin
                slot_q  <= 1'b1;
                drive_q <= ack_q;
              end else begin
                slot_q  <= 1'b0;
                drive_q <= 1'b0;
                cnt     <= '0;
                unique case (state)
                  ST_SEL_ACK: begin
                    if (dir_rd_q) begin
                      state <= ST_RD;
                      tx_q  <= rbuf;
                    end else begin
                      state <= ST_AHI;
                    end
                  end
                  ST_AHI_ACK: state <= ST_ALO;
                  default:    state <= ST_WR;
                endcase
              end
            end
          end

          ST_RD: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                state <= ST_RD_ACK;
                cnt   <= '0;
              end else begin
                cnt  <= cnt + 3'd1;
                tx_q <= {tx_q[6:0], 1'b0};
              end
            end
          end

          ST_RD_ACK: begin
            if (scl_rise) mack_q <= !sda_in;
            if (scl_fall) begin
              if (mack_q) begin
                state <= ST_RD;
                tx_q  <= rbuf;
                cnt   <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end

          default: begin
            cnt <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/smt_checks.sv
module smt_checks
  import smt_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      scl,
  input logic      wp,
  input logic      sda_oe,
  input logic      mem_we,
  input smt_addr_t mem_addr,
  input logic      data_byte_done,
  input logic      in_idle
);
  AST_OE_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl)) |-> $stable(sda_oe)); // R10

  AST_NO_WRITE_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp); // R7

  AST_ADDR_FROZEN_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_byte_done && wp) |=> $stable(mem_addr)); // R7

  AST_ADDR_STEP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == smt_next_addr($past(mem_addr)))); // R4

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe); // R6
endmodule

bind serial_mem_target smt_checks u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .scl            (scl),
  .wp             (wp),
  .sda_oe         (sda_oe),
  .mem_we         (mem_we),
  .mem_addr       (mem_addr),
  .data_byte_done (data_byte_done),
  .in_idle        (in_idle)
);

// File: tb/tb_serial_mem_target.sv
module tb_serial_mem_target;
  localparam int Q = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_m, sda_m, wp;
  logic [2:0] strap;
  logic sda_oe, mem_we, mem_re;
  logic [12:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  serial_mem_target dut (
    .clk(clk), .rst_n(rst_n), .scl(scl_m), .sda_in(sda_line), .wp(wp),
    .strap(strap), .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails = 0;
  int cur_a = 0;
  int exp_q[$];
  int r10_bad = 0;
  logic [7:0] hw[int];
  logic [7:0] refm[int];

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 37 + 11) ^ (a >> 5));
  endfunction

  function automatic logic [7:0] hw_rd(input int a);
    return hw.exists(a) ? hw[a] : init_val(a);
  endfunction

  function automatic logic [7:0] ref_rd(input int a);
    return refm.exists(a) ? refm[a] : init_val(a);
  endfunction

  function automatic int inc_a(input int a);
    return (a + 1) % 8192;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // array behind the synchronous port
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= hw_rd(int'(mem_addr));
    if (mem_we) hw[int'(mem_addr)] = mem_wdata;
  end

  // per-clock comparison with the reference stream
  logic scl_prev = 1'b1;
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (scl_prev && scl_m && (sda_oe != oe_prev)) r10_bad++;
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected write strobe", int'(mem_addr), 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk({19'd0, mem_addr, mem_wdata} == e, "R5", "write addr/data",
              {19'd0, mem_addr, mem_wdata}, e);
        end
      end
    end
    scl_prev = scl_m;
    oe_prev  = sda_oe;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    b = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    acked = (a == 1'b0);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(!give_ack);
  endtask

  // write select plus two address bytes; bus left with SCL low
  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    bit ak;
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, ak);
    chk(ak, "R9", "select ack before address", ak, 1);
    send_byte(hi, ak);
    chk(ak, req, "high address ack", ak, 1);
    send_byte(lo, ak);
    chk(ak, req, "low address ack", ak, 1);
    cur_a = {19'd0, hi[4:0], lo};
  endtask

  task automatic do_write(input logic [7:0] hi, input logic [7:0] lo, input int n,
                          input int base, input string req);
    bit ak;
    set_addr(hi, lo, "R2");
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(base + i * 13);
      if (!wp) begin
        exp_q.push_back((cur_a << 8) | int'(d));
        refm[cur_a] = d;
        cur_a = inc_a(cur_a);
      end
      send_byte(d, ak);
      chk(ak == !wp, wp ? "R7" : req, "data byte ack", ak, !wp);
    end
    bus_stop();
  endtask

  task automatic do_read(input int n, input string req);
    bit ak;
    logic [7:0] b;
    bus_start();
    send_byte({4'b1010, strap, 1'b1}, ak);
    chk(ak, "R1", "read select ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i < n - 1);
      chk(b == ref_rd(cur_a), req, "read byte", b, ref_rd(cur_a));
      cur_a = inc_a(cur_a);
    end
    chk(sda_oe == 1'b0, "R6", "released after host NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    bit ak;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0; strap = 3'b101;
    mem_rdata = 8'h00;
    wq(8);
    rst_n = 1'b1;
    wq(4);
    chk(sda_oe == 1'b0, "R6", "sda released after reset", sda_oe, 0);
    chk(!mem_we && !mem_re, "R5", "no strobes after reset", {mem_we, mem_re}, 0);

    // R3: first current read after reset starts at address 0
    do_read(1, "R3");

    // R5: burst write, then R9 select right after it via random read with Sr
    do_write(8'h01, 8'h23, 4, 8'h40, "R5");
    set_addr(8'hE1, 8'h23, "R2");   // top three bits ignored
    chk(cur_a == 32'h123, "R2", "model address", cur_a, 32'h123);
    do_read(4, "R6");               // repeated START keeps latch (R3)

    // R3: current-address read continues after the burst
    do_read(2, "R3");

    // R4: wrap on write and on read
    do_write(8'h1F, 8'hFE, 4, 8'h90, "R4");
    set_addr(8'h1F, 8'hFF, "R4");
    do_read(3, "R4");

    // R1: wrong strap gets no ACK and nothing is disturbed
    bus_start();
    send_byte({4'b1010, 3'b011, 1'b0}, ak);
    chk(!ak, "R1", "mismatched select nack", ak, 0);
    send_byte(8'h00, ak);
    chk(!ak, "R1", "ignored byte after mismatch", ak, 0);
    bus_stop();
    do_read(1, "R1");

    // R7: protect blocks write, ack and increment
    wp = 1'b1;
    do_write(8'h02, 8'h00, 2, 8'h55, "R7");
    wp = 1'b0;
    chk(cur_a == 32'h200, "R7", "model address frozen", cur_a, 32'h200);
    do_read(1, "R7");

    // R8: STOP in mid-byte drops the byte
    set_addr(8'h03, 8'h10, "R8");
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    bus_stop();
    do_read(1, "R8");

    // R8: START in mid-byte drops the byte
    set_addr(8'h03, 8'h20, "R8");
    for (int i = 0; i < 5; i++) bit_out(1'b1);
    do_read(1, "R8");

    // R5: long burst and read back
    do_write(8'h05, 8'h00, 20, 8'h07, "R5");
    set_addr(8'h05, 8'h00, "R5");
    do_read(20, "R5");

    wq(4);
    chk(exp_q.size() == 0, "R5", "all expected writes seen", exp_q.size(), 0);
    foreach (refm[k]) begin
      if (hw_rd(k) != refm[k]) chk(1'b0, "R5", "array content", hw_rd(k), refm[k]);
    end
    chk(r10_bad == 0, "R10", "sda_oe edges while SCL high", r10_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule